// File: doc/BRIEF.md
# Single-Operand Instruction Execution Unit

This block executes one instruction from the single-operand group of a 16-bit processor. It receives the instruction word, an operand that is already resolved, the current status flags, the stack pointer and the program counter. From these it produces a register result, the updated flags, a new stack pointer and program counter, and at most one memory write or a sequence of memory reads. The group holds two right rotates, byte swap, sign extension, push, subroutine call and return from interrupt. Each rotate and push runs on either a byte or a full word.

A pulse on `start` while the unit is idle launches one instruction. Register and push/call operations finish one clock later with a single-cycle `done` pulse, and the write strobes are valid in the same cycle. Return from interrupt reads two stack words in turn and finishes three clocks after `start`. Memory read data is taken combinationally in any cycle where `memRe` is high. Write strobes last one cycle, and the data outputs hold their values until the next instruction.

Top module: `sop_unit`

## Requirements
- R1: An instruction is legal only when bits 15..10 equal 000100 and the operation code in bits 9..7 is 0 (RRC), 1 (SWPB), 2 (RRA), 3 (SXT), 4 (PUSH), 5 (CALL) or 6 (RETI). Bit 6 is the byte select (1 = byte), bits 5..4 are the addressing mode and bits 3..0 are the register number. Code 7, any other prefix, and byte select set on SWPB, SXT, CALL or RETI all give `illegal` together with `done`. In that case `resultWe`, `pcWe`, `memWe` and `memRe` stay low, and the flags, SP and PC outputs copy their inputs.
- R2: Arithmetic rotate right (RRA) keeps the top bit of the operation width, moves the lowest bit into C, clears V, and sets N and Z from the result. In byte mode it acts on bits 7..0 and clears bits 15..8.
- R3: Rotate through carry (RRC) moves the incoming C into the top bit of the width and bit 0 into C. V is set when the incoming C is 1 and the operand's top bit is 0. N and Z follow the result. Byte mode acts on bits 7..0 and clears bits 15..8.
- R4: Byte swap (SWPB) exchanges bits 15..8 with bits 7..0 and passes all four flags through unchanged.
- R5: Sign extension (SXT) copies bit 7 into bits 15..8 and clears V. N is taken from bit 15, Z is set for a zero result, and C is the inverse of Z.
- R6: PUSH writes the operand to address SP-2 and returns SP-2 as the new SP. In byte mode the written word is the low byte with zeros above it. Flags are unchanged and the register result is not written.
- R7: CALL writes the incoming PC to address SP-2, returns SP-2, loads the operand into PC with `pcWe`, and leaves the flags unchanged.
- R8: RETI reads the status word at SP and then the PC word at SP+2. Flags are restored from status bits 8 (V), 2 (N), 1 (Z) and 0 (C). PC is loaded from the second word and the final SP is SP+4.
- R9: Register, push and call operations raise `done` exactly one clock after `start`, and RETI raises it three clocks after. `busy` is high during the RETI read cycles, and a `start` seen while busy is ignored.
- R10: After reset `done`, `illegal`, `busy`, `resultWe`, `pcWe`, `memWe` and `memRe` are all low. Flags on every flag port are ordered {V,N,Z,C}, from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch the presented instruction |
| instr | input | 16 | Instruction word |
| operand | input | 16 | Resolved operand value |
| flagsIn | input | 4 | Current flags {V,N,Z,C} |
| spIn | input | 16 | Current stack pointer |
| pcIn | input | 16 | Current program counter |
| memRdata | input | 16 | Memory read data for the current `memAddr` |
| busy | output | 1 | Multi-cycle operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completion was for an illegal instruction |
| result | output | 16 | Register result |
| resultWe | output | 1 | Write `result` back to the destination |
| dstField | output | 6 | Destination mode and register of the instruction |
| flagsOut | output | 4 | Updated flags {V,N,Z,C} |
| spOut | output | 16 | Updated stack pointer |
| pcOut | output | 16 | Updated program counter |
| pcWe | output | 1 | Load `pcOut` into PC |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |
| memAddr | output | 16 | Memory address |
| memWdata | output | 16 | Memory write data |

## Verification
The hardest situation to reach is a fresh `start` landing while return from interrupt is halfway through its two stack reads. The stimulus builds it by presenting a push with `start` high in the cycle after the return has begun. The bench then confirms three things: `done` still arrives exactly on the third clock, the final SP is the return's SP+4 and not a pushed value, and no word is written to memory below the original SP. Carry-in and sign-edge cases of the rotates in byte mode are driven with operands whose upper byte is nonzero, so that any leak from the upper byte shows up in the result or in N.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int DATA_W    = 16;
  localparam int FLAG_W    = 4;
  localparam int OPC_W     = 3;
  localparam int PREFIX_W  = 6;
  localparam logic [PREFIX_W-1:0] GROUP_PREFIX = 6'b000100;

  // status word bit positions used when restoring flags
  localparam int SR_C_POS = 0;
  localparam int SR_Z_POS = 1;
  localparam int SR_N_POS = 2;
  localparam int SR_V_POS = 8;

  // flag vector layout {V,N,Z,C}
  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_RRC  = 3'd0,
    OP_SWPB = 3'd1,
    OP_RRA  = 3'd2,
    OP_SXT  = 3'd3,
    OP_PUSH = 3'd4,
    OP_CALL = 3'd5,
    OP_RETI = 3'd6,
    OP_NONE = 3'd7
  } sopOp_e;

  typedef struct packed {
    logic   aluLoad;
    logic   pushLoad;
    logic   callLoad;
    logic   retiStart;
    logic   popSr;
    logic   popPc;
    logic   illegal;
    logic   byteMode;
    sopOp_e op;
  } sopStrobe_t;
endpackage

// File: rtl/sop_alu.sv
module sop_alu
  import sop_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  sopOp_e            op,
  input  logic              byteMode,
  input  logic [W-1:0]      operand,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [W-1:0]      res,
  output logic [FLAG_W-1:0] flagsOut
);
  localparam int HB = W / 2;

  logic msbIn;
  logic carryIn;
  logic updNZ;
  logic zeroRes;
  logic negRes;

  always_comb begin
    msbIn   = byteMode ? operand[HB-1] : operand[W-1];
    carryIn = flagsIn[F_C];
  end

  always_comb begin
    res      = operand;
    flagsOut = flagsIn;
    updNZ    = 1'b0;
    unique case (op)
      OP_RRA: begin
        if (byteMode) res = {{HB{1'b0}}, operand[HB-1], operand[HB-1:1]};
        else          res = {operand[W-1], operand[W-1:1]};
        flagsOut[F_C] = operand[0];
        flagsOut[F_V] = 1'b0;
        updNZ         = 1'b1;
      end
      OP_RRC: begin
        if (byteMode) res = {{HB{1'b0}}, carryIn, operand[HB-1:1]};
        else          res = {carryIn, operand[W-1:1]};
        flagsOut[F_C] = operand[0];
        flagsOut[F_V] = carryIn & ~msbIn;
        updNZ         = 1'b1;
      end
      OP_SWPB: begin
        res = {operand[HB-1:0], operand[W-1:HB]};
      end
      OP_SXT: begin
        res = {{HB{operand[HB-1]}}, operand[HB-1:0]};
        flagsOut[F_V] = 1'b0;
        updNZ         = 1'b1;
      end
      default: begin
        res = operand;
      end
    endcase
    negRes  = byteMode ? res[HB-1] : res[W-1];
    zeroRes = byteMode ? (res[HB-1:0] == '0) : (res == '0);
    if (updNZ) begin
      flagsOut[F_N] = negRes;
      flagsOut[F_Z] = zeroRes;
      if (op == OP_SXT) flagsOut[F_C] = ~zeroRes;
    end
  end
endmodule

// File: rtl/sop_ctrl.sv
module sop_ctrl
  import sop_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DATA_W-1:6] instrHi,
  output sopStrobe_t       strobe,
  output logic             busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_POP_SR, ST_POP_PC} ctrlState_e;

  ctrlState_e state, stateNext;
  sopOp_e     opDec;
  logic       byteSel;
  logic       groupOk;
  logic       legal;

  always_comb begin
    groupOk = (instrHi[DATA_W-1 -: PREFIX_W] == GROUP_PREFIX);
    opDec   = sopOp_e'(instrHi[9:7]);
    byteSel = instrHi[6];
    legal   = groupOk && (opDec != OP_NONE) &&
              !(byteSel && (opDec inside {OP_SWPB, OP_SXT, OP_CALL, OP_RETI}));
  end

  always_comb begin
    strobe          = '0;
    strobe.op       = opDec;
    strobe.byteMode = byteSel;
    stateNext       = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (!legal) begin
            strobe.illegal = 1'b1;
          end else begin
            unique case (opDec)
              OP_PUSH: strobe.pushLoad = 1'b1;
              OP_CALL: strobe.callLoad = 1'b1;
              OP_RETI: begin
                strobe.retiStart = 1'b1;
                stateNext        = ST_POP_SR;
              end
              default: strobe.aluLoad = 1'b1;
            endcase
          end
        end
      end
      ST_POP_SR: begin
        strobe.popSr = 1'b1;
        stateNext    = ST_POP_PC;
      end
      ST_POP_PC: begin
        strobe.popPc = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  // R8: status pop is always followed by the PC pop
  a_r8_sr_then_pc: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POP_SR) |=> (state == ST_POP_PC));

  // R9: at most one action strobe per cycle
  a_r9_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.aluLoad, strobe.pushLoad, strobe.callLoad, strobe.retiStart,
              strobe.popSr, strobe.popPc, strobe.illegal}));

  // R9: a start while busy launches nothing
  a_r9_busy_blocks_start: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strobe.aluLoad || strobe.pushLoad || strobe.callLoad ||
               strobe.retiStart || strobe.illegal));
endmodule

// File: rtl/sop_dp.sv
module sop_dp
  import sop_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sopStrobe_t        strobe,
  input  logic [W-1:0]      aluRes,
  input  logic [FLAG_W-1:0] aluFlags,
  input  logic [W-1:0]      operand,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [W-1:0]      spIn,
  input  logic [W-1:0]      pcIn,
  input  logic [5:0]        dstIn,
  input  logic [W-1:0]      memRdata,
  output logic              done,
  output logic              illegal,
  output logic [W-1:0]      result,
  output logic              resultWe,
  output logic [5:0]        dstField,
  output logic [FLAG_W-1:0] flagsOut,
  output logic [W-1:0]      spOut,
  output logic [W-1:0]      pcOut,
  output logic              pcWe,
  output logic              memWe,
  output logic              memRe,
  output logic [W-1:0]      memAddr,
  output logic [W-1:0]      memWdata
);
  localparam int HB = W / 2;
  localparam logic [W-1:0] STEP = W'(W / 8);

  logic [W-1:0]      spDec;
  logic [W-1:0]      spInc;
  logic [W-1:0]      pushData;
  logic [FLAG_W-1:0] popFlags;

  always_comb begin
    spDec    = spIn - STEP;
    spInc    = spOut + STEP;
    pushData = strobe.byteMode ? {{HB{1'b0}}, operand[HB-1:0]} : operand;
    popFlags = '0;
    popFlags[F_V] = memRdata[SR_V_POS];
    popFlags[F_N] = memRdata[SR_N_POS];
    popFlags[F_Z] = memRdata[SR_Z_POS];
    popFlags[F_C] = memRdata[SR_C_POS];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done     <= 1'b0;
      illegal  <= 1'b0;
      result   <= '0;
      resultWe <= 1'b0;
      dstField <= '0;
      flagsOut <= '0;
      spOut    <= '0;
      pcOut    <= '0;
      pcWe     <= 1'b0;
      memWe    <= 1'b0;
      memRe    <= 1'b0;
      memAddr  <= '0;
      memWdata <= '0;
    end else begin
      done     <= 1'b0;
      illegal  <= 1'b0;
      resultWe <= 1'b0;
      pcWe     <= 1'b0;
      memWe    <= 1'b0;
      memRe    <= 1'b0;
      if (strobe.aluLoad) begin
        result   <= aluRes;
        resultWe <= 1'b1;
        dstField <= dstIn;
        flagsOut <= aluFlags;
        spOut    <= spIn;
        pcOut    <= pcIn;
        done     <= 1'b1;
      end
      if (strobe.pushLoad) begin
        dstField <= dstIn;
        flagsOut <= flagsIn;
        spOut    <= spDec;
        pcOut    <= pcIn;
        memAddr  <= spDec;
        memWdata <= pushData;
        memWe    <= 1'b1;
        done     <= 1'b1;
      end
      if (strobe.callLoad) begin
        dstField <= dstIn;
        flagsOut <= flagsIn;
        spOut    <= spDec;
        pcOut    <= operand;
        pcWe     <= 1'b1;
        memAddr  <= spDec;
        memWdata <= pcIn;
        memWe    <= 1'b1;
        done     <= 1'b1;
      end
      if (strobe.retiStart) begin
        dstField <= dstIn;
        flagsOut <= flagsIn;
        spOut    <= spIn;
        pcOut    <= pcIn;
        memAddr  <= spIn;
        memRe    <= 1'b1;
      end
      if (strobe.popSr) begin
        flagsOut <= popFlags;
        spOut    <= spInc;
        memAddr  <= spInc;
        memRe    <= 1'b1;
      end
      if (strobe.popPc) begin
        pcOut <= memRdata;
        spOut <= spInc;
        pcWe  <= 1'b1;
        done  <= 1'b1;
      end
      if (strobe.illegal) begin
        dstField <= dstIn;
        flagsOut <= flagsIn;
        spOut    <= spIn;
        pcOut    <= pcIn;
        illegal  <= 1'b1;
        done     <= 1'b1;
      end
    end
  end

  // R1: an illegal completion carries no write or read strobe
  a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (done && !resultWe && !pcWe && !memWe && !memRe));

  // R6: a stack write always lands on the reported new SP
  a_r6_write_at_sp: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr == spOut));

  // R8: consecutive stack reads climb by one word
  a_r8_pop_advance: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && $past(memRe)) |-> (memAddr == $past(memAddr) + STEP));

  // R9: a write and a read never share a cycle
  a_r9_mem_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));
endmodule

// File: rtl/sop_unit.sv
module sop_unit
  import sop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [15:0] instr,
  input  logic [15:0] operand,
  input  logic [3:0]  flagsIn,
  input  logic [15:0] spIn,
  input  logic [15:0] pcIn,
  input  logic [15:0] memRdata,
  output logic        busy,
  output logic        done,
  output logic        illegal,
  output logic [15:0] result,
  output logic        resultWe,
  output logic [5:0]  dstField,
  output logic [3:0]  flagsOut,
  output logic [15:0] spOut,
  output logic [15:0] pcOut,
  output logic        pcWe,
  output logic        memWe,
  output logic        memRe,
  output logic [15:0] memAddr,
  output logic [15:0] memWdata
);
  sopStrobe_t        strobe;
  logic [15:0]       aluRes;
  logic [FLAG_W-1:0] aluFlags;

  sop_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .instrHi (instr[15:6]),
    .strobe  (strobe),
    .busy    (busy)
  );

  sop_alu #(.W(DATA_W)) u_alu (
    .op       (strobe.op),
    .byteMode (strobe.byteMode),
    .operand  (operand),
    .flagsIn  (flagsIn),
    .res      (aluRes),
    .flagsOut (aluFlags)
  );

  sop_dp #(.W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .aluRes   (aluRes),
    .aluFlags (aluFlags),
    .operand  (operand),
    .flagsIn  (flagsIn),
    .spIn     (spIn),
    .pcIn     (pcIn),
    .dstIn    (instr[5:0]),
    .memRdata (memRdata),
    .done     (done),
    .illegal  (illegal),
    .result   (result),
    .resultWe (resultWe),
    .dstField (dstField),
    .flagsOut (flagsOut),
    .spOut    (spOut),
    .pcOut    (pcOut),
    .pcWe     (pcWe),
    .memWe    (memWe),
    .memRe    (memRe),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );
endmodule

// File: tb/sop_unit_test.sv
`timescale 1ns/1ps
module sop_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0, operand = '0, spIn = '0, pcIn = '0;
  logic [3:0]  flagsIn = '0;
  logic [15:0] memRdata;
  logic        busy, done, illegal, resultWe, pcWe, memWe, memRe;
  logic [15:0] result, spOut, pcOut, memAddr, memWdata;
  logic [5:0]  dstField;
  logic [3:0]  flagsOut;
  logic [15:0] mem [0:255];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sop_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .operand(operand),
    .flagsIn(flagsIn), .spIn(spIn), .pcIn(pcIn), .memRdata(memRdata),
    .busy(busy), .done(done), .illegal(illegal), .result(result),
    .resultWe(resultWe), .dstField(dstField), .flagsOut(flagsOut),
    .spOut(spOut), .pcOut(pcOut), .pcWe(pcWe), .memWe(memWe), .memRe(memRe),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  assign memRdata = mem[memAddr[8:1]];
  always @(posedge clk) if (memWe) mem[memAddr[8:1]] <= memWdata;

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one instruction; returns at the negedge after the accepting edge
  task automatic launch(input logic [15:0] i, input logic [15:0] op,
                        input logic [3:0] f, input logic [15:0] sp, input logic [15:0] pc);
    @(negedge clk);
    instr = i; operand = op; flagsIn = f; spIn = sp; pcIn = pc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic aluCase(input string req, input logic [15:0] i, input logic [15:0] op,
                         input logic [3:0] f, input logic [15:0] expRes, input logic [3:0] expF);
    launch(i, op, f, 16'h0200, 16'h1000);
    chk(req, "done", {15'd0, done}, 16'd1);
    chk(req, "resultWe", {15'd0, resultWe}, 16'd1);
    chk(req, "result", result, expRes);
    chk(req, "flags", {12'd0, flagsOut}, {12'd0, expF});
    chk(req, "dst", {10'd0, dstField}, {10'd0, i[5:0]});
  endtask

  task automatic testReset;
    chk("R10", "done", {15'd0, done}, 16'd0);
    chk("R10", "busy", {15'd0, busy}, 16'd0);
    chk("R10", "strobes", {11'd0, illegal, resultWe, pcWe, memWe, memRe}, 16'd0);
  endtask

  task automatic testRotates;
    aluCase("R2", 16'h1105, 16'h8001, 4'b1000, 16'hC000, 4'b0101);
    aluCase("R2", 16'h1143, 16'h1281, 4'b0000, 16'h00C0, 4'b0101);
    aluCase("R2", 16'h1100, 16'h0001, 4'b0000, 16'h0000, 4'b0011);
    aluCase("R3", 16'h1007, 16'h0002, 4'b0001, 16'h8001, 4'b1100);
    aluCase("R3", 16'h1042, 16'hFF01, 4'b0000, 16'h0000, 4'b0011);
    aluCase("R3", 16'h1041, 16'h7F80, 4'b0001, 16'h00C0, 4'b0100);
  endtask

  task automatic testSwapSxt;
    aluCase("R4", 16'h1089, 16'h12AB, 4'b1010, 16'hAB12, 4'b1010);
    aluCase("R5", 16'h1184, 16'h0080, 4'b1000, 16'hFF80, 4'b0101);
    aluCase("R5", 16'h1184, 16'hFF00, 4'b1101, 16'h0000, 4'b0010);
  endtask

  task automatic testPush;
    launch(16'h1204, 16'hBEEF, 4'b1010, 16'h0100, 16'h1000);
    chk("R9", "push done", {15'd0, done}, 16'd1);
    chk("R6", "memWe", {15'd0, memWe}, 16'd1);
    chk("R6", "addr", memAddr, 16'h00FE);
    chk("R6", "sp", spOut, 16'h00FE);
    chk("R6", "flags", {12'd0, flagsOut}, 16'h000A);
    chk("R6", "resultWe", {15'd0, resultWe}, 16'd0);
    @(negedge clk);
    chk("R6", "mem word", mem[8'h7F], 16'hBEEF);
    launch(16'h1244, 16'hBEEF, 4'b0000, 16'h00FE, 16'h1000);
    chk("R6", "byte data", memWdata, 16'h00EF);
    chk("R6", "byte sp", spOut, 16'h00FC);
  endtask

  task automatic testCall;
    launch(16'h1285, 16'h1234, 4'b0110, 16'h0080, 16'h4444);
    chk("R7", "memWe", {15'd0, memWe}, 16'd1);
    chk("R7", "addr", memAddr, 16'h007E);
    chk("R7", "wdata", memWdata, 16'h4444);
    chk("R7", "pc", pcOut, 16'h1234);
    chk("R7", "pcWe", {15'd0, pcWe}, 16'd1);
    chk("R7", "flags", {12'd0, flagsOut}, 16'h0006);
    @(negedge clk);
    chk("R7", "mem", mem[8'h3F], 16'h4444);
  endtask

  task automatic testReti;
    mem[8'h20] = 16'h0105;   // V=1 N=1 Z=0 C=1
    mem[8'h21] = 16'h5678;
    mem[8'h1F] = 16'h0000;
    launch(16'h1300, 16'h0000, 4'b0010, 16'h0040, 16'h2222);
    chk("R9", "busy", {15'd0, busy}, 16'd1);
    chk("R9", "no early done", {15'd0, done}, 16'd0);
    // a push presented while busy must be ignored
    instr = 16'h1204; operand = 16'hDEAD; spIn = 16'h0040; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "no mid done", {15'd0, done}, 16'd0);
    chk("R8", "memRe", {15'd0, memRe}, 16'd1);
    @(negedge clk);
    chk("R9", "reti done", {15'd0, done}, 16'd1);
    chk("R8", "pc", pcOut, 16'h5678);
    chk("R8", "pcWe", {15'd0, pcWe}, 16'd1);
    chk("R8", "sp", spOut, 16'h0044);
    chk("R8", "flags", {12'd0, flagsOut}, 16'h000D);
    @(negedge clk);
    chk("R9", "no extra done", {15'd0, done}, 16'd0);
    chk("R9", "no stray push", mem[8'h1F], 16'h0000);
    chk("R9", "sp held", spOut, 16'h0044);
  endtask

  task automatic illegalCase(input logic [15:0] i);
    launch(i, 16'hAAAA, 4'b1001, 16'h0300, 16'h0777);
    chk("R1", "done", {15'd0, done}, 16'd1);
    chk("R1", "illegal", {15'd0, illegal}, 16'd1);
    chk("R1", "strobes", {12'd0, resultWe, pcWe, memWe, memRe}, 16'd0);
    chk("R1", "flags", {12'd0, flagsOut}, 16'h0009);
    chk("R1", "sp", spOut, 16'h0300);
    chk("R1", "pc", pcOut, 16'h0777);
  endtask

  task automatic testIllegal;
    illegalCase(16'h1380);
    illegalCase(16'h2000);
    illegalCase(16'h10C0);
    illegalCase(16'h1340);
    launch(16'h1105, 16'h0004, 4'b0000, 16'h0200, 16'h1000);
    chk("R1", "legal not flagged", {15'd0, illegal}, 16'd0);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 16'h0000;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testRotates();
    testSwapSxt();
    testPush();
    testCall();
    testReti();
    testIllegal();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule